// File: doc/BRIEF.md
# Slot-Based Priority Interrupt Controller

This block watches a wide set of level-sensitive peripheral request lines. It tells a processor core when a request is pending whose urgency is high enough for the core to take. The core gets the winning vector number, that vector's urgency level and a jump address, which is a programmable base plus twice the vector number.

Every source starts at level 0. Software can move a source to level 1 or level 2 by writing its number into one of a small set of slot registers. There are three slots per raised level. Each slot has a valid bit. The arbiter works as follows:

- It takes the highest level that has an active request.
- Within that level, the lowest vector number wins.
- The winner goes to the core only if its level beats the core's current priority level.

The top vector is user-assignable. When it wins, a fast-interrupt flag is raised.

Top module: `slot_irq_ctrl`

## Requirements
- R1: After reset, every source is at level 0, the base register holds 0, and `irq_o`, `vec_o`, `lvl_o`, `fast_o` and `vec_addr_o` are all 0.
- R2: Within one level, the active request with the lowest vector number wins.
- R3: A source named in a valid level-1 slot is reported at level 1 and beats any level-0 request, whatever its vector number.
- R4: A source named in a valid level-2 slot is reported at level 2 and beats any level-1 or level-0 request.
- R5: A slot whose valid bit (write data bit 15) is clear assigns no level to the source number it holds.
- R6: A source named in both a level-1 slot and a level-2 slot is treated as level 2.
- R7: The winner is offered (`irq_o`=1) only if its level is strictly greater than `core_lvl_i`, or if both its level and `core_lvl_i` are 0. Otherwise `irq_o`, `vec_o`, `lvl_o` and `fast_o` are 0.
- R8: `vec_addr_o` equals base + 2 × `vec_o` and updates one clock after `vec_o`.
- R9: `fast_o` is 1 exactly when `irq_o` is 1 and the winning vector is NUM_SRC-1 (vector 50 by default).
- R10: The request lines are level-sensitive. The outputs follow the inputs one clock after a change, so `irq_o` drops the cycle after the last qualifying request goes away.
- R11: Register map on `wr_addr_i`: addresses 0–2 are the level-1 slots, 3–5 are the level-2 slots and 6 is the base. A slot takes the source number from data bits 5:0 and the valid bit from bit 15. A write to address 7 changes nothing.
- R12: Rewriting a slot replaces its old source. The old source goes back to level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Level-sensitive request lines, bit n is vector n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | SEL_W | Register select |
| wr_data_i | input | DATA_W | Register write data |
| core_lvl_i | input | 2 | Core's current priority level, 0 to 3 |
| irq_o | output | 1 | Qualifying interrupt pending |
| vec_o | output | SRC_W | Winning vector number |
| lvl_o | output | 2 | Level of the winning vector |
| fast_o | output | 1 | Winner is the fast-capable top vector |
| vec_addr_o | output | ADDR_W | Jump address, base + 2 × vector |

## Verification
The bench uses the default parameters: 51 sources, three slots per raised level, and a 16-bit data path and address. With these values, vector 50 can be driven as the fast source. Two slots can name the same source across levels, one slot can be loaded but left invalid, and the unused address 7 can be written. All four core levels, 0 through 3, are applied, so each acceptance case and the fully masked state are reached.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  typedef enum logic [1:0] {
    LVL_0 = 2'd0,
    LVL_1 = 2'd1,
    LVL_2 = 2'd2
  } lvl_e;
endpackage

// File: rtl/slot_irq_regs.sv
module slot_irq_regs #(
  parameter int SLOTS  = 3,
  parameter int SRC_W  = 6,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [2*SLOTS-1:0]          slot_vld_o,
  output logic [2*SLOTS-1:0][SRC_W-1:0] slot_src_o,
  output logic [ADDR_W-1:0]           base_o
);
  localparam int NSLOT    = 2 * SLOTS;
  localparam int BASE_SEL = NSLOT;
  localparam int VLD_BIT  = DATA_W - 1;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_vld_o[k] <= 1'b0;
        slot_src_o[k] <= '0;
      end else if (wr_en_i && wr_addr_i == SEL_W'(k)) begin
        slot_vld_o[k] <= wr_data_i[VLD_BIT];
        slot_src_o[k] <= wr_data_i[SRC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           base_o <= '0;
    else if (wr_en_i && wr_addr_i == SEL_W'(BASE_SEL))    base_o <= wr_data_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/slot_irq_level_map.sv
module slot_irq_level_map #(
  parameter int NUM_SRC = 51,
  parameter int SLOTS   = 3,
  parameter int SRC_W   = 6
) (
  input  logic [NUM_SRC-1:0]            irq_i,
  input  logic [2*SLOTS-1:0]            slot_vld_i,
  input  logic [2*SLOTS-1:0][SRC_W-1:0] slot_src_i,
  output logic [NUM_SRC-1:0]            req_l0_o,
  output logic [NUM_SRC-1:0]            req_l1_o,
  output logic [NUM_SRC-1:0]            req_l2_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic in_l1, in_l2;
    always_comb begin
      in_l1 = 1'b0;
      in_l2 = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
        if (slot_vld_i[k] && slot_src_i[k] == SRC_W'(s))             in_l1 = 1'b1;
        if (slot_vld_i[SLOTS+k] && slot_src_i[SLOTS+k] == SRC_W'(s)) in_l2 = 1'b1;
      end
    end
    // level 2 wins over a duplicate level-1 slot
    assign req_l2_o[s] = irq_i[s] & in_l2;
    assign req_l1_o[s] = irq_i[s] & in_l1 & ~in_l2;
    assign req_l0_o[s] = irq_i[s] & ~in_l1 & ~in_l2;
  end
endmodule

// File: rtl/slot_irq_arbiter.sv
module slot_irq_arbiter
  import slot_irq_pkg::*;
#(
  parameter int NUM_SRC = 51,
  parameter int SRC_W   = 6
) (
  input  logic [NUM_SRC-1:0] req_l0_i,
  input  logic [NUM_SRC-1:0] req_l1_i,
  input  logic [NUM_SRC-1:0] req_l2_i,
  input  logic [1:0]         core_lvl_i,
  output logic               hit_o,
  output logic [SRC_W-1:0]   vec_o,
  output lvl_e               lvl_o
);
  function automatic logic [SRC_W-1:0] low_idx(input logic [NUM_SRC-1:0] v);
    low_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) low_idx = SRC_W'(i);
  endfunction

  logic any_l0, any_l1, any_l2, any_req;
  assign any_l0  = |req_l0_i;
  assign any_l1  = |req_l1_i;
  assign any_l2  = |req_l2_i;
  assign any_req = any_l0 | any_l1 | any_l2;

  always_comb begin
    if (any_l2) begin
      lvl_o = LVL_2;
      vec_o = low_idx(req_l2_i);
    end else if (any_l1) begin
      lvl_o = LVL_1;
      vec_o = low_idx(req_l1_i);
    end else begin
      lvl_o = LVL_0;
      vec_o = low_idx(req_l0_i);
    end
  end

  assign hit_o = any_req &&
                 ((2'(lvl_o) > core_lvl_i) || (lvl_o == LVL_0 && core_lvl_i == 2'd0));
endmodule

// File: rtl/slot_irq_ctrl.sv
module slot_irq_ctrl
  import slot_irq_pkg::*;
#(
  parameter int NUM_SRC = 51,
  parameter int SLOTS   = 3,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int SEL_W  = $clog2(2 * SLOTS + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [1:0]         core_lvl_i,
  output logic               irq_o,
  output logic [SRC_W-1:0]   vec_o,
  output logic [1:0]         lvl_o,
  output logic               fast_o,
  output logic [ADDR_W-1:0]  vec_addr_o
);
  localparam logic [SRC_W-1:0] FAST_VEC = SRC_W'(NUM_SRC - 1);

  logic [2*SLOTS-1:0]            slot_vld;
  logic [2*SLOTS-1:0][SRC_W-1:0] slot_src;
  logic [ADDR_W-1:0]             base_q;
  logic [NUM_SRC-1:0]            req_l0, req_l1, req_l2;
  logic                          win_hit;
  logic [SRC_W-1:0]              win_vec;
  lvl_e                          win_lvl;

  slot_irq_regs #(
    .SLOTS(SLOTS), .SRC_W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .slot_vld_o(slot_vld), .slot_src_o(slot_src), .base_o(base_q)
  );

  slot_irq_level_map #(
    .NUM_SRC(NUM_SRC), .SLOTS(SLOTS), .SRC_W(SRC_W)
  ) u_map (
    .irq_i, .slot_vld_i(slot_vld), .slot_src_i(slot_src),
    .req_l0_o(req_l0), .req_l1_o(req_l1), .req_l2_o(req_l2)
  );

  slot_irq_arbiter #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)
  ) u_arb (
    .req_l0_i(req_l0), .req_l1_i(req_l1), .req_l2_i(req_l2), .core_lvl_i,
    .hit_o(win_hit), .vec_o(win_vec), .lvl_o(win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      vec_o      <= '0;
      lvl_o      <= 2'd0;
      fast_o     <= 1'b0;
      vec_addr_o <= '0;
    end else begin
      irq_o      <= win_hit;
      vec_o      <= win_hit ? win_vec : '0;
      lvl_o      <= win_hit ? 2'(win_lvl) : 2'd0;
      fast_o     <= win_hit && (win_vec == FAST_VEC);
      vec_addr_o <= base_q + (ADDR_W'(vec_o) << 1);
    end
  end
endmodule

// File: rtl/slot_irq_ctrl_chk.sv
module slot_irq_ctrl_chk #(
  parameter int NUM_SRC = 51,
  parameter int SRC_W   = 6,
  parameter int ADDR_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic [1:0]         core_lvl_i,
  input logic               irq_o,
  input logic [SRC_W-1:0]   vec_o,
  input logic [1:0]         lvl_o,
  input logic               fast_o,
  input logic [ADDR_W-1:0]  vec_addr_o,
  input logic [ADDR_W-1:0]  base_q
);
  a_r9_fast_top_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> (irq_o && vec_o == SRC_W'(NUM_SRC - 1)));

  a_r8_addr_trails_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> vec_addr_o == $past(base_q) + (ADDR_W'($past(vec_o)) << 1));

  a_r7_masked_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_lvl_i == 2'd3) |=> !irq_o);

  a_r7_level_beats_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(rst_ni)) |-> ((lvl_o > $past(core_lvl_i)) ||
                                  (lvl_o == 2'd0 && $past(core_lvl_i) == 2'd0)));

  a_r10_idle_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |=> !irq_o);

  a_r2_winner_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((($past(irq_i) >> vec_o) & NUM_SRC'(1)) != '0));
endmodule

bind slot_irq_ctrl slot_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .core_lvl_i(core_lvl_i),
  .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o), .fast_o(fast_o),
  .vec_addr_o(vec_addr_o), .base_q(base_q)
);

// File: tb/slot_irq_ctrl_tb.sv
module slot_irq_ctrl_tb;
  localparam int NUM_SRC = 51;
  localparam int SRC_W   = 6;
  localparam int SEL_W   = 3;
  localparam logic [15:0] BASE = 16'h1000;

  typedef struct packed {
    logic [63:0] mask;
    logic [1:0]  core;
    logic        irq;
    logic [5:0]  vec;
    logic [1:0]  lvl;
    logic        fast;
    logic [7:0]  req;
  } vec_t;

  function automatic logic [63:0] b(input int n);
    b = 64'd1 << n;
  endfunction

  // slot setup: L1 = {10,20,30}, L2 = {40,20,invalid 5}
  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{b(3)|b(7),        2'd0, 1'b1, 6'd3,  2'd0, 1'b0, 8'd2},  // R2
    '{b(7)|b(10),       2'd0, 1'b1, 6'd10, 2'd1, 1'b0, 8'd3},  // R3
    '{b(10)|b(30),      2'd0, 1'b1, 6'd10, 2'd1, 1'b0, 8'd2},  // R2
    '{b(10)|b(40),      2'd0, 1'b1, 6'd40, 2'd2, 1'b0, 8'd4},  // R4
    '{b(20)|b(30)|b(40),2'd0, 1'b1, 6'd20, 2'd2, 1'b0, 8'd6},  // R6
    '{b(5)|b(6),        2'd0, 1'b1, 6'd5,  2'd0, 1'b0, 8'd5},  // R5
    '{b(3),             2'd1, 1'b0, 6'd0,  2'd0, 1'b0, 8'd7},  // R7
    '{b(10),            2'd1, 1'b0, 6'd0,  2'd0, 1'b0, 8'd7},  // R7
    '{b(40),            2'd1, 1'b1, 6'd40, 2'd2, 1'b0, 8'd7},  // R7
    '{b(10),            2'd0, 1'b1, 6'd10, 2'd1, 1'b0, 8'd7},  // R7
    '{b(40),            2'd2, 1'b0, 6'd0,  2'd0, 1'b0, 8'd7},  // R7
    '{b(50),            2'd0, 1'b1, 6'd50, 2'd0, 1'b1, 8'd9},  // R9
    '{b(50)|b(49),      2'd0, 1'b1, 6'd49, 2'd0, 1'b0, 8'd9},  // R9
    '{b(0),             2'd3, 1'b0, 6'd0,  2'd0, 1'b0, 8'd7},  // R7
    '{64'd0,            2'd0, 1'b0, 6'd0,  2'd0, 1'b0, 8'd10}  // R10
  };

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_SRC-1:0] irq_i = '0;
  logic               wr_en_i = 1'b0;
  logic [SEL_W-1:0]   wr_addr_i = '0;
  logic [15:0]        wr_data_i = '0;
  logic [1:0]         core_lvl_i = '0;
  logic               irq_o;
  logic [SRC_W-1:0]   vec_o;
  logic [1:0]         lvl_o;
  logic               fast_o;
  logic [15:0]        vec_addr_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] base_exp = '0;

  always #4 clk_i = ~clk_i;

  slot_irq_ctrl u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = SEL_W'(a); wr_data_i = 16'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // drive at a negedge; check flags one edge later, address one edge after that
  task automatic apply(input string req, input logic [63:0] m, input logic [1:0] c,
                       input logic e_irq, input int e_vec, input int e_lvl, input logic e_fast);
    irq_i = m[NUM_SRC-1:0]; core_lvl_i = c;
    @(negedge clk_i);
    check(req, int'(irq_o), int'(e_irq));
    check(req, int'(vec_o), e_vec);
    check(req, int'(lvl_o), e_lvl);
    check(req, int'(fast_o), int'(e_fast));
    @(negedge clk_i);
    check({req, " addr"}, int'(vec_addr_o), int'(base_exp) + 2 * e_vec);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1", int'(irq_o), 0);
    check("R1", int'(vec_o), 0);
    check("R1", int'(vec_addr_o), 0);
    apply("R1", b(40), 2'd0, 1'b1, 40, 0, 1'b0);

    // R11 configuration through the map
    wr(0, 16'h8000 | 10);
    wr(1, 16'h8000 | 20);
    wr(2, 16'h8000 | 30);
    wr(3, 16'h8000 | 40);
    wr(4, 16'h8000 | 20);
    wr(5, 5);
    wr(6, BASE);
    base_exp = BASE;

    for (int i = 0; i < NV; i++)
      apply($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].mask, TBL[i].core,
            TBL[i].irq, int'(TBL[i].vec), int'(TBL[i].lvl), TBL[i].fast);

    // R10 level-sensitive drop and handover
    apply("R10", b(3) | b(10), 2'd0, 1'b1, 10, 1, 1'b0);
    apply("R10", b(3), 2'd0, 1'b1, 3, 0, 1'b0);
    apply("R10", 64'd0, 2'd0, 1'b0, 0, 0, 1'b0);

    // R8 address lags vector by one cycle
    apply("R8", b(10), 2'd0, 1'b1, 10, 1, 1'b0);
    irq_i = b(40)[NUM_SRC-1:0];
    @(negedge clk_i);
    check("R8", int'(vec_o), 40);
    check("R8 old addr", int'(vec_addr_o), int'(BASE) + 20);
    @(negedge clk_i);
    check("R8 new addr", int'(vec_addr_o), int'(BASE) + 80);
    wr(6, 16'h2000);
    base_exp = 16'h2000;
    apply("R8 new base", b(40), 2'd0, 1'b1, 40, 2, 1'b0);

    // R11 address 7 is ignored
    wr(7, 16'hFFFF);
    apply("R11", b(7), 2'd0, 1'b1, 7, 0, 1'b0);

    // R12 slot rewrite releases old source
    wr(0, 16'h8000 | 11);
    apply("R12", b(10) | b(11), 2'd0, 1'b1, 11, 1, 1'b0);
    apply("R12", b(10), 2'd0, 1'b1, 10, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule